// File: doc/BRIEF.md
# Mask and Shift Condition Code Unit

This unit produces a 2-bit condition code for three operation families: test-under-mask, insert-under-mask and arithmetic left shift. Each operation is evaluated at either 32-bit or 64-bit width. The caller presents a selector, a width mode and two 64-bit operands. Operand A is always the value or the shift source. Operand B is either the mask or, for a shift, the shift count.

The unit does not produce the shifted data and does not perform the insertion. It only classifies the outcome. That classification needs two pieces of logic:

- a priority search for the most significant set bit of the mask;
- a per-bit overflow comparison that checks every bit a left shift pushes past the sign bit against that sign bit.

The result is registered and appears one clock after an input-valid pulse. It comes with a one-cycle valid strobe.

Top module: `mscc_unit`

## Requirements
- R1: After reset, `res_vld` = 0, `res_cc` = 0 and `res_err` = 0.
- R2: `res_vld` pulses high in exactly the cycle after each cycle with `req_vld` = 1 and is low otherwise. `res_cc` changes only on such a cycle and otherwise holds its value.
- R3: Test-under-mask (`req_op` = 0): the code is 0 when A AND B is zero, which includes an all-zero mask. The code is 3 when A AND B equals B.
- R4: Test-under-mask at 32-bit width (`req_wide` = 0): any mixed result (neither zero nor full) gives code 1.
- R5: Test-under-mask at 64-bit width (`req_wide` = 1): a mixed result gives 2 when A has a 1 at the position of B's most significant set bit, and 1 when A has a 0 there.
- R6: Insert-under-mask (`req_op` = 1): the code is 0 when A AND B is zero. Otherwise it is 1 when A has a 1 at B's most significant set bit, and 2 when A has a 0 there.
- R7: Arithmetic left shift (`req_op` = 2) by count n: the code is 3 when any of the n source bits directly below the sign bit differs from the sign bit. At 64-bit width the sign is bit 63 and n is B[5:0].
- R8: A shift that does not overflow gives 0 for a zero source, 1 for a negative source and 2 for a positive source. A count of zero never overflows.
- R9: At 32-bit width, only bits 31:0 of A and B take part, the sign bit is bit 31, and the shift count is B[4:0] (B[5] is ignored).
- R10: Selector value 3 is unused. It makes `res_err` pulse with `res_vld`, and `res_cc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Request strobe |
| req_op | input | 2 | 0 test, 1 insert, 2 shift, 3 unused |
| req_wide | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| req_a | input | 64 | Value or shift source |
| req_b | input | 64 | Mask, or shift count in the low bits |
| res_vld | output | 1 | Result strobe, one cycle after request |
| res_cc | output | 2 | Registered condition code |
| res_err | output | 1 | Unused selector flag, valid with `res_vld` |

## Verification
The bench goes after the following corners:

- **Mask priority search.** Masks with two set bits are paired with a value that has a 1 at only one of them. A search that picked the lowest bit, or that looked at all 64 bits in 32-bit mode, returns the opposite code.
- **Zero mask.** A zero mask must give code 0 rather than 3. A design that tested for "full" first would report 3.
- **Shift overflow span.** Shifts by 0, 1, 31, 62 and 63 probe the edges of the checked span. An off-by-one span either misses the lowest shifted-out bit or flags the sign bit against itself.
- **32-bit isolation.** In 32-bit mode, the upper operand bits and count bit 5 are loaded with values that would change the answer if they leaked in.

// File: rtl/mscc_pkg.sv
package mscc_pkg;
    localparam int DATA_W = 64;
    localparam int HALF_W = DATA_W / 2;
    localparam int POS_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        OP_TEST   = 2'd0,
        OP_INSERT = 2'd1,
        OP_SHIFT  = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] cc;
        logic       err;
    } res_t;
endpackage

// File: rtl/mscc_lead_find.sv
module mscc_lead_find #(
    parameter int W = 64,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos
);
    // Upward scan: the last set bit seen is the most significant one.
    always_comb begin
        pos = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) pos = PW'(i);
        end
    end
endmodule

// File: rtl/mscc_shift_eval.sv
module mscc_shift_eval #(
    parameter int W = 64,
    localparam int HW = W / 2,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  src,
    input  logic [CW-1:0] cnt,
    input  logic          wide,
    output logic          ovf,
    output logic [1:0]    cls
);
    logic [CW-1:0] cnt_eff;
    logic          sign;
    logic          low_nz;
    logic [W-2:0]  diff;

    always_comb begin
        cnt_eff = wide ? cnt : {1'b0, cnt[CW-2:0]};
        sign    = wide ? src[W-1] : src[HW-1];
        low_nz  = wide ? (|src[W-2:0]) : (|src[HW-2:0]);
    end

    // Bit i is pushed past the sign bit when i + n reaches the sign index.
    genvar gi;
    generate
        for (gi = 0; gi < W - 1; gi++) begin : g_bit
            always_comb begin
                if (wide) begin
                    diff[gi] = (gi + int'(cnt_eff) >= W - 1) && (src[gi] != sign);
                end else if (gi < HW - 1) begin
                    diff[gi] = (gi + int'(cnt_eff) >= HW - 1) && (src[gi] != sign);
                end else begin
                    diff[gi] = 1'b0;
                end
            end
        end
    endgenerate

    // Without overflow the kept sign plus the preserved low bits decide the class.
    always_comb begin
        ovf = |diff;
        if (sign)        cls = 2'd1;
        else if (low_nz) cls = 2'd2;
        else             cls = 2'd0;
    end
endmodule

// File: rtl/mscc_unit.sv
module mscc_unit
    import mscc_pkg::*;
#(
    parameter int W = DATA_W,
    localparam int HW = W / 2,
    localparam int PW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_vld,
    input  logic [1:0]   req_op,
    input  logic         req_wide,
    input  logic [W-1:0] req_a,
    input  logic [W-1:0] req_b,
    output logic         res_vld,
    output logic [1:0]   res_cc,
    output logic         res_err
);
    res_t          res_d, res_q;
    logic [W-1:0]  val_m, msk_m, hit;
    logic [PW-1:0] top_pos;
    logic          top_bit;
    logic          sh_ovf;
    logic [1:0]    sh_cls;

    always_comb begin
        val_m = req_wide ? req_a : {{HW{1'b0}}, req_a[HW-1:0]};
        msk_m = req_wide ? req_b : {{HW{1'b0}}, req_b[HW-1:0]};
        hit   = val_m & msk_m;
    end

    mscc_lead_find #(.W(W)) u_lead (
        .vec (msk_m),
        .pos (top_pos)
    );

    assign top_bit = val_m[top_pos];

    mscc_shift_eval #(.W(W)) u_shift (
        .src  (req_a),
        .cnt  (req_b[PW-1:0]),
        .wide (req_wide),
        .ovf  (sh_ovf),
        .cls  (sh_cls)
    );

    always_comb begin
        res_d     = res_q;
        res_d.vld = req_vld;
        res_d.err = 1'b0;
        if (req_vld) begin
            unique case (op_e'(req_op))
                OP_TEST: begin
                    if (hit == '0)        res_d.cc = 2'd0;
                    else if (hit == msk_m) res_d.cc = 2'd3;
                    else if (!req_wide)   res_d.cc = 2'd1;
                    else                  res_d.cc = top_bit ? 2'd2 : 2'd1;
                end
                OP_INSERT: begin
                    if (hit == '0) res_d.cc = 2'd0;
                    else           res_d.cc = top_bit ? 2'd1 : 2'd2;
                end
                OP_SHIFT: begin
                    res_d.cc = sh_ovf ? 2'd3 : sh_cls;
                end
                default: begin
                    res_d.cc  = 2'd0;
                    res_d.err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res_vld = res_q.vld;
    assign res_cc  = res_q.cc;
    assign res_err = res_q.err;
endmodule

// File: rtl/mscc_unit_chk.sv
module mscc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [1:0]  req_op,
    input logic        req_wide,
    input logic [63:0] req_a,
    input logic [63:0] req_b,
    input logic        res_vld,
    input logic [1:0]  res_cc,
    input logic        res_err
);
    p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!res_vld && !res_err && $stable(res_cc)));
    p_full_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd0 && req_wide && (req_a & req_b) == 64'd0) |=> res_cc == 2'd0);
    p_ins_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd1 && req_wide && (req_a & req_b) == 64'd0) |=> res_cc == 2'd0);
    p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd2 && req_wide && req_b[5:0] == 6'd1 && req_a[63] != req_a[62])
        |=> res_cc == 2'd3);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd2 && req_wide && req_b[5:0] == 6'd0) |=> res_cc != 2'd3);
    p_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op == 2'd3) |=> (res_err && res_cc == 2'd0));
    p_err_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_op != 2'd3) |=> !res_err);
endmodule

bind mscc_unit mscc_unit_chk u_chk (.*);

// File: tb/mscc_unit_tb_top.sv
module mscc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic        wide;
        logic [63:0] a;
        logic [63:0] b;
        logic [1:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 64'h00F0, 64'h000F, 2'd0, 4'd3},                      // R3 zero
        '{2'd0, 1'b1, 64'h00FF, 64'h000F, 2'd3, 4'd3},                      // R3 full
        '{2'd0, 1'b0, 64'h0001, 64'h0003, 2'd1, 4'd4},                      // R4
        '{2'd0, 1'b0, 64'h0002, 64'h0003, 2'd1, 4'd4},                      // R4 top set
        '{2'd0, 1'b1, 64'h0002, 64'h0003, 2'd2, 4'd5},                      // R5
        '{2'd0, 1'b1, 64'h0001, 64'h0003, 2'd1, 4'd5},                      // R5
        '{2'd0, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 2'd2, 4'd5}, // R5
        '{2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd0, 4'd3},          // R3 zero mask
        '{2'd1, 1'b1, 64'h0080, 64'h00F0, 2'd1, 4'd6},                      // R6
        '{2'd1, 1'b1, 64'h0010, 64'h00F0, 2'd2, 4'd6},                      // R6
        '{2'd1, 1'b1, 64'h000F, 64'h00F0, 2'd0, 4'd6},                      // R6
        '{2'd2, 1'b1, 64'h4000_0000_0000_0000, 64'd1, 2'd3, 4'd7},          // R7
        '{2'd2, 1'b1, 64'h2000_0000_0000_0000, 64'd1, 2'd2, 4'd8},          // R8
        '{2'd2, 1'b1, 64'hC000_0000_0000_0000, 64'd1, 2'd1, 4'd8},          // R8
        '{2'd2, 1'b1, 64'h0, 64'd5, 2'd0, 4'd8},                            // R8
        '{2'd2, 1'b1, 64'h8000_0000_0000_0000, 64'd0, 2'd1, 4'd8},          // R8 count 0
        '{2'd2, 1'b1, 64'h4000_0000_0000_0000, 64'd0, 2'd2, 4'd8},          // R8 count 0
        '{2'd2, 1'b1, 64'h1, 64'd63, 2'd3, 4'd7},                           // R7 widest
        '{2'd2, 1'b1, 64'h1, 64'd62, 2'd2, 4'd8},                           // R8
        '{2'd2, 1'b0, 64'hFFFF_FFFF_4000_0000, 64'd1, 2'd3, 4'd9},          // R9
        '{2'd2, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h21, 2'd2, 4'd9},         // R9 bit5 ignored
        '{2'd0, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_00FF, 2'd0, 4'd9}, // R9
        '{2'd1, 1'b0, 64'h0000_0000_8000_0000, 64'hFFFF_0000_8000_0001, 2'd1, 4'd9}, // R9
        '{2'd2, 1'b0, 64'h8000_0000, 64'd31, 2'd3, 4'd7}                    // R7 32-bit
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_wide = 1'b0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic        res_vld;
    logic [1:0]  res_cc;
    logic        res_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mscc_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (req_vld),
        .req_op   (req_op),
        .req_wide (req_wide),
        .req_a    (req_a),
        .req_b    (req_b),
        .res_vld  (res_vld),
        .res_cc   (res_cc),
        .res_err  (res_err)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic wide,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        req_op = op; req_wide = wide; req_a = a; req_b = b; req_vld = 1'b1;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 vld", {3'b0, res_vld}, 4'd0);
        check("R1 cc", {2'b0, res_cc}, 4'd0);
        check("R1 err", {3'b0, res_err}, 4'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].wide, VECS[i].a, VECS[i].b);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), {2'b0, res_cc}, {2'b0, VECS[i].exp});
            check("R2 strobe", {3'b0, res_vld}, 4'd1);
        end

        // R2: idle cycle, strobe drops and code holds (last vector gave 3)
        @(negedge clk);
        req_a = 64'h0; req_b = 64'h0; req_op = 2'd0;
        @(negedge clk);
        check("R2 idle vld", {3'b0, res_vld}, 4'd0);
        check("R2 hold cc", {2'b0, res_cc}, 4'd3);

        // R10: unused selector
        issue(2'd3, 1'b1, 64'hFF, 64'hFF);
        check("R10 err", {3'b0, res_err}, 4'd1);
        check("R10 cc", {2'b0, res_cc}, 4'd0);
        check("R10 vld", {3'b0, res_vld}, 4'd1);
        @(negedge clk);
        check("R10 err clears", {3'b0, res_err}, 4'd0);

        // R2: back-to-back requests each produce a result
        @(negedge clk);
        req_op = 2'd0; req_wide = 1'b1; req_a = 64'hFF; req_b = 64'h0F; req_vld = 1'b1;
        @(negedge clk);
        check("R2 b2b first", {2'b0, res_cc}, 4'd3);
        req_op = 2'd1; req_a = 64'h1; req_b = 64'h3;
        @(negedge clk);
        req_vld = 1'b0;
        check("R2 b2b second", {2'b0, res_cc}, 4'd2);
        check("R2 b2b vld", {3'b0, res_vld}, 4'd1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule